// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits on the path from the CPU to memory and lets a load-reserved / store-conditional pair work as an atomic primitive. It keeps one reservation flag for the entire physical address space, with no address comparison. A CPU request of the reserve kind sets the flag. Plain stores, whether from the CPU or from any other bus master, clear it. So does every conditional store, and so does reset.

Plain reads, plain stores and reserve loads pass straight through to memory in the same cycle. The block adds no register stage to them. A conditional store is forwarded as a write only if the flag is set when it is issued. In that case the CPU sees the memory's ack and error, and the read data is replaced by the code 0. If the flag is clear, the write is dropped. The block then answers the CPU itself one cycle later with an ack, no error and the code 1.

Top module: `rsv_monitor`

## Requirements
- R1: After reset the reservation is clear, so the first conditional store fails, and neither `cpu_rsp_ack` nor `mem_req_valid` is high while no request is present.
- R2: A request with `cpu_req_kind` = 2'b01 (reserve load) is forwarded to memory unchanged and sets the reservation. Any address counts, since the whole address space is one granule.
- R3: A request with `cpu_req_kind` = 2'b10 (conditional store) issued while the reservation is set is forwarded as a write. Its response carries the memory's ack and error, with read data equal to 0.
- R4: A conditional store issued while the reservation is clear leaves memory untouched (`mem_req_valid` stays low). The block then returns `cpu_rsp_ack` = 1, `cpu_rsp_err` = 0 and read data equal to 1 in the following cycle.
- R5: Every conditional store, whether it succeeds or fails, clears the reservation.
- R6: A CPU write with `cpu_req_kind` = 2'b00 or 2'b11 (plain store) clears the reservation.
- R7: A pulse on any bit of `ext_store_valid` clears the reservation. These bits are store strobes from the other bus masters: cache, DMA and debugger.
- R8: When an invalidating store and a reserve load occur in the same cycle, the reservation ends up clear.
- R9: Requests other than conditional stores reach the memory side in the same cycle, with the same fields, and their responses pass back unchanged.
- R10: The conditional-store result code is zero-extended to `DATA_W` bits, whatever the memory returns on its read-data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | CPU request strobe, one cycle per request |
| cpu_req_kind | input | 2 | 00 plain, 01 reserve load, 10 conditional store, 11 plain |
| cpu_req_we | input | 1 | CPU write enable |
| cpu_req_addr | input | ADDR_W | CPU byte address |
| cpu_req_wdata | input | DATA_W | CPU write data |
| cpu_req_be | input | DATA_W/8 | CPU byte enables |
| cpu_rsp_ack | output | 1 | Response strobe to the CPU |
| cpu_rsp_err | output | 1 | Response error to the CPU |
| cpu_rsp_rdata | output | DATA_W | Response data, or the conditional-store code |
| ext_store_valid | input | NUM_EXT | Store strobes from other bus masters |
| mem_req_valid | output | 1 | Request strobe toward memory |
| mem_req_we | output | 1 | Write enable toward memory |
| mem_req_addr | output | ADDR_W | Address toward memory |
| mem_req_wdata | output | DATA_W | Write data toward memory |
| mem_req_be | output | DATA_W/8 | Byte enables toward memory |
| mem_rsp_ack | input | 1 | Memory response strobe |
| mem_rsp_err | input | 1 | Memory response error |
| mem_rsp_rdata | input | DATA_W | Memory read data |

## Verification
A conditional store is tried in four situations. It is tried straight after reset, after a reserve load, and directly after another conditional store. It is also tried after a reserve load followed by one of these: a CPU plain store, the reserved kind encoding, or each external master strobe separately. Each of these separates the paths that clear the flag from the one that sets it. A reserve load with a simultaneous external store shows whether the clear takes priority. A reserve load to one address followed by a conditional store to another shows that no address is compared. A conditional store to an address where memory returns an error, and plain writes answered with all-ones data, show that the error passes through while the result code replaces the data.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'b00,
    KIND_LR    = 2'b01,
    KIND_SC    = 2'b10,
    KIND_RSVD  = 2'b11
  } req_kind_e;

  localparam int unsigned SC_CODE_OK   = 0;
  localparam int unsigned SC_CODE_FAIL = 1;

endpackage

// File: rtl/rsv_inval.sv
module rsv_inval #(
  parameter int unsigned NUM_EXT = 3
) (
  input  logic               cpu_store,
  input  logic [NUM_EXT-1:0] ext_store,
  output logic               kill
);

  logic [NUM_EXT:0] chain;

  assign chain[0] = cpu_store;

  generate
    for (genvar gi = 0; gi < NUM_EXT; gi++) begin : g_src
      assign chain[gi+1] = chain[gi] | ext_store[gi];
    end
  endgenerate

  assign kill = chain[NUM_EXT];

endmodule

// File: rtl/rsv_flag.sv
module rsv_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  output logic rsv_valid
);

  logic flag_q;
  logic flag_d;
  logic flag_en;

  // clear dominates set
  always_comb begin
    flag_en = set_req | clr_req;
    flag_d  = flag_q;
    if (clr_req) begin
      flag_d = 1'b0;
    end else if (set_req) begin
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign rsv_valid = flag_q;

endmodule

// File: rtl/rsv_sc_route.sv
module rsv_sc_route
  import rsv_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_sc,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  input  logic              rsv_valid,
  output logic              rsp_ack,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dn_valid,
  output logic              dn_we,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [DATA_W-1:0] dn_wdata,
  output logic [BE_W-1:0]   dn_be,
  input  logic              dn_ack,
  input  logic              dn_err,
  input  logic [DATA_W-1:0] dn_rdata
);

  logic sc_go;
  logic sc_drop;
  logic local_ack_q, local_ack_d, local_ack_en;
  logic sc_wait_q, sc_wait_d, sc_wait_en;

  assign sc_go   = req_valid & req_is_sc &  rsv_valid;
  assign sc_drop = req_valid & req_is_sc & ~rsv_valid;

  // downstream request: straight through unless dropped
  assign dn_valid = req_valid & ~sc_drop;
  assign dn_we    = req_we;
  assign dn_addr  = req_addr;
  assign dn_wdata = req_wdata;
  assign dn_be    = req_be;

  always_comb begin
    local_ack_d  = sc_drop;
    local_ack_en = sc_drop | local_ack_q;
    sc_wait_d    = sc_wait_q;
    sc_wait_en   = sc_go | (sc_wait_q & dn_ack);
    if (sc_go) begin
      sc_wait_d = 1'b1;
    end else if (sc_wait_q & dn_ack) begin
      sc_wait_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_ack_q <= 1'b0;
    end else if (local_ack_en) begin
      local_ack_q <= local_ack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_wait_q <= 1'b0;
    end else if (sc_wait_en) begin
      sc_wait_q <= sc_wait_d;
    end
  end

  always_comb begin
    rsp_ack   = local_ack_q | dn_ack;
    rsp_err   = dn_err & ~local_ack_q;
    rsp_rdata = dn_rdata;
    if (local_ack_q) begin
      rsp_rdata = DATA_W'(SC_CODE_FAIL);
    end else if (sc_wait_q) begin
      rsp_rdata = DATA_W'(SC_CODE_OK);
    end
  end

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor
  import rsv_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_EXT = 3,
  localparam int unsigned BE_W   = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_valid,
  input  logic [1:0]         cpu_req_kind,
  input  logic               cpu_req_we,
  input  logic [ADDR_W-1:0]  cpu_req_addr,
  input  logic [DATA_W-1:0]  cpu_req_wdata,
  input  logic [BE_W-1:0]    cpu_req_be,
  output logic               cpu_rsp_ack,
  output logic               cpu_rsp_err,
  output logic [DATA_W-1:0]  cpu_rsp_rdata,
  input  logic [NUM_EXT-1:0] ext_store_valid,
  output logic               mem_req_valid,
  output logic               mem_req_we,
  output logic [ADDR_W-1:0]  mem_req_addr,
  output logic [DATA_W-1:0]  mem_req_wdata,
  output logic [BE_W-1:0]    mem_req_be,
  input  logic               mem_rsp_ack,
  input  logic               mem_rsp_err,
  input  logic [DATA_W-1:0]  mem_rsp_rdata
);

  req_kind_e kind;
  logic      is_sc;
  logic      is_lr;
  logic      cpu_plain_store;
  logic      kill;
  logic      rsv_valid;

  assign kind            = req_kind_e'(cpu_req_kind);
  assign is_sc           = (kind == KIND_SC);
  assign is_lr           = (kind == KIND_LR);
  assign cpu_plain_store = cpu_req_valid & cpu_req_we &
                           ((kind == KIND_PLAIN) | (kind == KIND_RSVD));

  rsv_inval #(.NUM_EXT(NUM_EXT)) u_inval (
    .cpu_store (cpu_plain_store),
    .ext_store (ext_store_valid),
    .kill      (kill)
  );

  rsv_flag u_flag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_req   (cpu_req_valid & is_lr),
    .clr_req   (kill | (cpu_req_valid & is_sc)),
    .rsv_valid (rsv_valid)
  );

  rsv_sc_route #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cpu_req_valid),
    .req_is_sc (is_sc),
    .req_we    (cpu_req_we),
    .req_addr  (cpu_req_addr),
    .req_wdata (cpu_req_wdata),
    .req_be    (cpu_req_be),
    .rsv_valid (rsv_valid),
    .rsp_ack   (cpu_rsp_ack),
    .rsp_err   (cpu_rsp_err),
    .rsp_rdata (cpu_rsp_rdata),
    .dn_valid  (mem_req_valid),
    .dn_we     (mem_req_we),
    .dn_addr   (mem_req_addr),
    .dn_wdata  (mem_req_wdata),
    .dn_be     (mem_req_be),
    .dn_ack    (mem_rsp_ack),
    .dn_err    (mem_rsp_err),
    .dn_rdata  (mem_rsp_rdata)
  );

endmodule

// File: rtl/rsv_monitor_chk.sv
module rsv_monitor_chk #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned NUM_EXT = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_req_valid,
  input logic [1:0]         cpu_req_kind,
  input logic               cpu_req_we,
  input logic [ADDR_W-1:0]  cpu_req_addr,
  input logic               cpu_rsp_ack,
  input logic               cpu_rsp_err,
  input logic [DATA_W-1:0]  cpu_rsp_rdata,
  input logic [NUM_EXT-1:0] ext_store_valid,
  input logic               mem_req_valid,
  input logic               mem_req_we,
  input logic [ADDR_W-1:0]  mem_req_addr,
  input logic               rsv_valid
);

  logic sc_req;
  logic lr_req;
  assign sc_req = cpu_req_valid && (cpu_req_kind == 2'b10);
  assign lr_req = cpu_req_valid && (cpu_req_kind == 2'b01);

  a_r4_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !rsv_valid) |-> !mem_req_valid);

  a_r4_local_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_req && !rsv_valid) |=>
      (cpu_rsp_ack && !cpu_rsp_err && cpu_rsp_rdata == DATA_W'(1)));

  a_r5_sc_clears: assert property (@(posedge clk) disable iff (!rst_n)
    sc_req |=> !rsv_valid);

  a_r7_ext_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (|ext_store_valid) |=> !rsv_valid);

  a_r2_lr_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (lr_req && !(|ext_store_valid)) |=> rsv_valid);

  a_r9_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req_valid && cpu_req_kind != 2'b10) |->
      (mem_req_valid && mem_req_addr == cpu_req_addr && mem_req_we == cpu_req_we));

endmodule

bind rsv_monitor rsv_monitor_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EXT(NUM_EXT)
) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cpu_req_valid   (cpu_req_valid),
  .cpu_req_kind    (cpu_req_kind),
  .cpu_req_we      (cpu_req_we),
  .cpu_req_addr    (cpu_req_addr),
  .cpu_rsp_ack     (cpu_rsp_ack),
  .cpu_rsp_err     (cpu_rsp_err),
  .cpu_rsp_rdata   (cpu_rsp_rdata),
  .ext_store_valid (ext_store_valid),
  .mem_req_valid   (mem_req_valid),
  .mem_req_we      (mem_req_we),
  .mem_req_addr    (mem_req_addr),
  .rsv_valid       (rsv_valid)
);

// File: tb/tb_rsv_monitor.sv
module tb_rsv_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NE = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_req_valid = 1'b0;
  logic [1:0]    cpu_req_kind = 2'b00;
  logic          cpu_req_we = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic [3:0]    cpu_req_be = 4'hF;
  logic          cpu_rsp_ack;
  logic          cpu_rsp_err;
  logic [DW-1:0] cpu_rsp_rdata;
  logic [NE-1:0] ext_store_valid = '0;
  logic          mem_req_valid;
  logic          mem_req_we;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic [3:0]    mem_req_be;
  logic          mem_rsp_ack = 1'b0;
  logic          mem_rsp_err = 1'b0;
  logic [DW-1:0] mem_rsp_rdata = '0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rsv_monitor #(.ADDR_W(AW), .DATA_W(DW), .NUM_EXT(NE)) dut (.*);

  // memory model: 16 words, acks one cycle after the request, errors at word 15
  logic [DW-1:0] mem [16];
  logic          pend_q = 1'b0;
  logic          pwe_q = 1'b0;
  logic [3:0]    padr_q = '0;
  logic [DW-1:0] pwd_q = '0;

  initial for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + i;

  always @(posedge clk) begin
    pend_q <= mem_req_valid;
    pwe_q  <= mem_req_we;
    padr_q <= mem_req_addr[3:0];
    pwd_q  <= mem_req_wdata;
  end

  always @(negedge clk) begin
    mem_rsp_ack <= 1'b0;
    mem_rsp_err <= 1'b0;
    if (pend_q) begin
      mem_rsp_ack <= 1'b1;
      mem_rsp_err <= (padr_q == 4'd15);
      if (pwe_q) begin
        mem_rsp_rdata <= 32'hFFFF_FFFF;
        if (padr_q != 4'd15) mem[padr_q] <= pwd_q;
      end else begin
        mem_rsp_rdata <= mem[padr_q];
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [DW-1:0] rdata;
    logic          err;
    string         tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    #1;
    if (rst_n && cpu_rsp_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "unexpected response", cpu_rsp_rdata, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cpu_rsp_rdata == e.rdata, {e.tag, " rdata"}, cpu_rsp_rdata, e.rdata);
        check(cpu_rsp_err == e.err, {e.tag, " err"}, DW'(cpu_rsp_err), DW'(e.err));
      end
    end
  end

  task automatic do_req(input logic [1:0] kind, input logic we, input int addr,
                        input logic [DW-1:0] wd, input logic [NE-1:0] ext,
                        input logic [DW-1:0] exp_rd, input logic exp_err,
                        input logic exp_fwd, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_req_valid   = 1'b1;
    cpu_req_kind    = kind;
    cpu_req_we      = we;
    cpu_req_addr    = AW'(addr * 4) >> 2;
    cpu_req_wdata   = wd;
    ext_store_valid = ext;
    e.rdata = exp_rd; e.err = exp_err; e.tag = tag;
    exp_q.push_back(e);
    #1;
    check(mem_req_valid == exp_fwd, {tag, " forward"}, DW'(mem_req_valid), DW'(exp_fwd));
    if (exp_fwd)
      check(mem_req_addr == cpu_req_addr && mem_req_wdata == wd,
            {tag, " R9 fields"}, mem_req_addr, cpu_req_addr);
    @(negedge clk);
    cpu_req_valid   = 1'b0;
    ext_store_valid = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic ext_pulse(input logic [NE-1:0] ext);
    @(negedge clk);
    ext_store_valid = ext;
    @(negedge clk);
    ext_store_valid = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!cpu_rsp_ack && !mem_req_valid, "R1 reset idle", DW'(cpu_rsp_ack), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R4: SC straight after reset fails, memory untouched
    do_req(2'b10, 1'b1, 2, 32'h1234, '0, 32'd1, 1'b0, 1'b0, "R1 R4 sc after reset");
    check(mem[2] == 32'hA000_0002, "R4 memory untouched", mem[2], 32'hA000_0002);

    // R2/R3/R10: LR then SC succeeds, code zero-extended
    do_req(2'b01, 1'b0, 3, '0, '0, 32'hA000_0003, 1'b0, 1'b1, "R2 lr read");
    do_req(2'b10, 1'b1, 3, 32'h1111, '0, 32'd0, 1'b0, 1'b1, "R3 R10 sc success");
    check(mem[3] == 32'h1111, "R3 memory written", mem[3], 32'h1111);

    // R5: second SC fails
    do_req(2'b10, 1'b1, 3, 32'h2222, '0, 32'd1, 1'b0, 1'b0, "R5 second sc");
    check(mem[3] == 32'h1111, "R5 memory kept", mem[3], 32'h1111);

    // R6: CPU plain store clears; R9 plain store passes back memory data
    do_req(2'b01, 1'b0, 4, '0, '0, 32'hA000_0004, 1'b0, 1'b1, "R2 lr");
    do_req(2'b00, 1'b1, 5, 32'h55, '0, 32'hFFFF_FFFF, 1'b0, 1'b1, "R9 plain store");
    do_req(2'b10, 1'b1, 4, 32'h44, '0, 32'd1, 1'b0, 1'b0, "R6 sc after store");

    // R6: reserved kind encoding acts as plain store
    do_req(2'b01, 1'b0, 10, '0, '0, 32'hA000_000A, 1'b0, 1'b1, "R2 lr");
    do_req(2'b11, 1'b1, 11, 32'hBB, '0, 32'hFFFF_FFFF, 1'b0, 1'b1, "R6 kind3 store");
    do_req(2'b10, 1'b1, 10, 32'hAA, '0, 32'd1, 1'b0, 1'b0, "R6 sc after kind3");

    // R7: each external master
    for (int i = 0; i < NE; i++) begin
      do_req(2'b01, 1'b0, 6, '0, '0, 32'hA000_0006, 1'b0, 1'b1, "R2 lr");
      ext_pulse(NE'(1) << i);
      do_req(2'b10, 1'b1, 6, 32'h66, '0, 32'd1, 1'b0, 1'b0, "R7 sc after ext store");
    end

    // R8: LR together with an external store
    do_req(2'b01, 1'b0, 7, '0, 3'b001, 32'hA000_0007, 1'b0, 1'b1, "R8 lr with store");
    do_req(2'b10, 1'b1, 7, 32'h77, '0, 32'd1, 1'b0, 1'b0, "R8 sc fails");

    // R2: single granule, SC to another address succeeds
    do_req(2'b01, 1'b0, 8, '0, '0, 32'hA000_0008, 1'b0, 1'b1, "R2 lr a");
    do_req(2'b01, 1'b0, 9, '0, '0, 32'hA000_0009, 1'b0, 1'b1, "R2 lr b");
    do_req(2'b10, 1'b1, 12, 32'hC0DE, '0, 32'd0, 1'b0, 1'b1, "R2 sc other address");
    check(mem[12] == 32'hC0DE, "R2 memory written", mem[12], 32'hC0DE);

    // R3/R9: error from memory passes through
    do_req(2'b01, 1'b0, 15, '0, '0, 32'hA000_000F, 1'b1, 1'b1, "R9 lr error");
    do_req(2'b10, 1'b1, 15, 32'hF, '0, 32'd0, 1'b1, 1'b1, "R3 sc error");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "responses outstanding", DW'(exp_q.size()), '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 5000, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule